// File: doc/BRIEF.md
# Multi-Port MDIO Management Slave

This block is the device side of a two-wire serial management bus for a chip that carries eight independent ports. All eight ports share one clock pin and one bidirectional data pin. Each port holds a small file of 16-bit registers and answers at its own bus address. That address is a five-bit base strap plus the port's index.

The block oversamples the management clock and data with the system clock. It parses each frame in order: the all-ones preamble, the start and operation bits, the device address, the register address, the turnaround, and then sixteen data bits. On a write it stores the data in the addressed port's register. On a read it takes the data pin through the turnaround and shifts the register out.

A disable input silences the whole interface. A reduced-strap mode clears the low three base bits, so only four base addresses can be chosen. A parallel local port lets on-chip logic read and write the same registers.

Top module: `mdio_mport_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones are sampled on the data pin. A frame with a shorter preamble is neither answered nor written, and a longer preamble is accepted.
- R2: After the preamble, the start bits must be 0 then 1, and the operation bits must be 1,0 (read) or 0,1 (write). Any other pattern abandons the frame with no write and no drive.
- R3: The device and register addresses are five bits each, sent MSB first. Port p answers when the device address equals (base + p) modulo 32, for p from 0 to 7.
- R4: On a matched read, data is sampled and launched on rising clock edges. The slave leaves the pin released for the first turnaround bit and drives 0 for the second. It then drives D15 down to D0 and releases the pin after D0.
- R5: On a matched write, the 16 bits after the turnaround, MSB first, are stored in the addressed register of the addressed port.
- R6: A frame whose address matches no port is followed to its end with no drive and no write. The slave then waits for a new full preamble and answers the next matched frame.
- R7: While the disable input is high, frames cause no write and the pin is never driven. Once the input is low again, reads work.
- R8: With the reduced-strap input high, base bits 2:0 are taken as zero and only base bits 4:3 apply.
- R9: Each port implements registers 0 to 3. A read of any other register returns zero with normal bus timing, and a write to one changes no stored register.
- R10: A local write stores to the selected port and register at the next system clock. The local read output shows the selected register combinationally, and MDIO reads return locally written data.
- R11: After reset every register is zero and the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than 4x the management clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the controller |
| mdio_i | input | 1 | Data pin input |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe_o | output | 1 | Data pin output enable |
| mgmt_dis_i | input | 1 | High disables the whole interface |
| strap_lite_i | input | 1 | Reduced-strap mode: base bits 2:0 forced to zero |
| base_addr_i | input | 5 | Base address strap |
| loc_we_i | input | 1 | Local write strobe |
| loc_port_i | input | 3 | Local port select |
| loc_addr_i | input | 5 | Local register select |
| loc_wdata_i | input | 16 | Local write data |
| loc_rdata_o | output | 16 | Local read data |

## Verification
The assertions check these rules on every cycle:
- the pin is released within one cycle of the disable input going high;
- the output enable rises only on a clock-edge event and is set only during the reply window of a matched read;
- the second turnaround bit is driven as zero;
- the start state is reached only from a full preamble count;
- a store strobe follows only a matched write.

Other behaviour can only be shown by the bench scenarios. These cover:
- the data values returned and stored;
- the modulo-32 address arithmetic and the reduced-strap base;
- the rejection of short preambles and bad start or operation bits;
- reads of unimplemented registers;
- the path between the local port and the bus.

// File: rtl/mdio_mps_pkg.sv
package mdio_mps_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    S_PRE,
    S_ST,
    S_OP,
    S_PHY,
    S_REG,
    S_TA,
    S_DATA
  } mps_state_e;
endpackage

// File: rtl/mdio_mps_sync.sv
module mdio_mps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic rise_o,
  output logic bit_o
);
  logic [STAGES-1:0] mdc_sh_q;
  logic [STAGES-1:0] dat_sh_q;
  logic              mdc_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_sh_q   <= '0;
      dat_sh_q   <= '1;
      mdc_last_q <= 1'b0;
    end else begin
      mdc_sh_q   <= {mdc_sh_q[STAGES-2:0], mdc_i};
      dat_sh_q   <= {dat_sh_q[STAGES-2:0], mdio_i};
      mdc_last_q <= mdc_sh_q[STAGES-1];
    end
  end

  assign rise_o = mdc_sh_q[STAGES-1] & ~mdc_last_q;
  assign bit_o  = dat_sh_q[STAGES-1];
endmodule

// File: rtl/mdio_mps_fsm.sv
module mdio_mps_fsm
  import mdio_mps_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PRE_LEN   = 32,
  localparam int PW  = $clog2(NUM_PORTS),
  localparam int PCW = $clog2(PRE_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic              dis_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [PW-1:0]     port_o,
  output logic [ADDR_W-1:0] reg_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  mps_state_e        state_q;
  logic [PCW-1:0]    pre_cnt_q;
  logic [3:0]        bit_cnt_q;
  logic              op_hi_q;
  logic              is_rd_q;
  logic              hit_q;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] reg_q;
  logic [PW-1:0]     port_q;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              wr_en_q;
  logic              oe_q;

  // offset of the frame address from the base, wraps modulo 32
  logic [ADDR_W-1:0] diff;
  logic              hit_c;
  assign diff  = phy_q - base_i;
  assign hit_c = int'(diff) < NUM_PORTS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_PRE;
      pre_cnt_q <= '0;
      bit_cnt_q <= '0;
      op_hi_q   <= 1'b0;
      is_rd_q   <= 1'b0;
      hit_q     <= 1'b0;
      phy_q     <= '0;
      reg_q     <= '0;
      port_q    <= '0;
      shift_q   <= '0;
      wr_data_q <= '0;
      wr_en_q   <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (dis_i) begin
        state_q   <= S_PRE;
        pre_cnt_q <= '0;
        bit_cnt_q <= '0;
        hit_q     <= 1'b0;
        oe_q      <= 1'b0;
      end else if (rise_i) begin
        unique case (state_q)
          S_PRE: begin
            if (bit_i) begin
              if (pre_cnt_q != PCW'(PRE_LEN)) pre_cnt_q <= pre_cnt_q + 1'b1;
            end else if (pre_cnt_q == PCW'(PRE_LEN)) begin
              state_q   <= S_ST;
              pre_cnt_q <= '0;
            end else begin
              pre_cnt_q <= '0;
            end
          end
          S_ST: begin
            bit_cnt_q <= '0;
            state_q   <= bit_i ? S_OP : S_PRE;
          end
          S_OP: begin
            if (bit_cnt_q == 4'd0) begin
              op_hi_q   <= bit_i;
              bit_cnt_q <= 4'd1;
            end else begin
              bit_cnt_q <= '0;
              if (op_hi_q != bit_i) begin
                is_rd_q <= op_hi_q;
                state_q <= S_PHY;
              end else begin
                state_q <= S_PRE;
              end
            end
          end
          S_PHY: begin
            phy_q <= {phy_q[ADDR_W-2:0], bit_i};
            if (bit_cnt_q == 4'(ADDR_W - 1)) begin
              bit_cnt_q <= '0;
              state_q   <= S_REG;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          S_REG: begin
            reg_q <= {reg_q[ADDR_W-2:0], bit_i};
            if (bit_cnt_q == 4'(ADDR_W - 1)) begin
              bit_cnt_q <= '0;
              state_q   <= S_TA;
              hit_q     <= hit_c;
              port_q    <= diff[PW-1:0];
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          S_TA: begin
            if (bit_cnt_q == 4'd0) begin
              bit_cnt_q <= 4'd1;
              shift_q   <= rd_data_i;
              if (is_rd_q && hit_q) oe_q <= 1'b1;
            end else begin
              bit_cnt_q <= '0;
              state_q   <= S_DATA;
            end
          end
          S_DATA: begin
            shift_q <= {shift_q[DATA_W-2:0], bit_i};
            if (bit_cnt_q == 4'(DATA_W - 1)) begin
              state_q   <= S_PRE;
              bit_cnt_q <= '0;
              pre_cnt_q <= '0;
              oe_q      <= 1'b0;
              if (!is_rd_q && hit_q) begin
                wr_en_q   <= 1'b1;
                wr_data_q <= {shift_q[DATA_W-2:0], bit_i};
              end
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          default: state_q <= S_PRE;
        endcase
      end
    end
  end

  assign port_o    = port_q;
  assign reg_o     = reg_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;
  assign mdio_o    = (state_q == S_DATA) ? shift_q[DATA_W-1] : 1'b0;
  assign mdio_oe_o = oe_q;

  a_r7_dis_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !oe_q);
  a_r4_oe_in_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (state_q == S_TA || state_q == S_DATA));
  a_r4_ta_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && state_q == S_TA) |-> !mdio_o);
  a_r4_oe_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(rise_i));
  a_r6_drive_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (hit_q && is_rd_q));
  a_r1_full_preamble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ST && $past(state_q) == S_PRE) |-> $past(pre_cnt_q) == PCW'(PRE_LEN));
  a_r5_store_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> $past(hit_q && !is_rd_q));
endmodule

// File: rtl/mdio_mps_regs.sv
module mdio_mps_regs
  import mdio_mps_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_REGS  = 4,
  localparam int PW   = $clog2(NUM_PORTS),
  localparam int NENT = NUM_PORTS * NUM_REGS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m_we_i,
  input  logic [PW-1:0]     m_port_i,
  input  logic [ADDR_W-1:0] m_addr_i,
  input  logic [DATA_W-1:0] m_wdata_i,
  output logic [DATA_W-1:0] m_rdata_o,
  input  logic              l_we_i,
  input  logic [PW-1:0]     l_port_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o
);
  logic [NENT-1:0][DATA_W-1:0] mem_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic sel_m, sel_l;
      assign sel_m = m_we_i && (m_port_i == PW'(p)) && (m_addr_i == ADDR_W'(r));
      assign sel_l = l_we_i && (l_port_i == PW'(p)) && (l_addr_i == ADDR_W'(r));
      // bus write wins over a local write to the same entry
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    mem_q[p*NUM_REGS+r] <= '0;
        else if (sel_m) mem_q[p*NUM_REGS+r] <= m_wdata_i;
        else if (sel_l) mem_q[p*NUM_REGS+r] <= l_wdata_i;
      end
    end
  end

  function automatic logic [DATA_W-1:0] pick(input logic [PW-1:0] p,
                                             input logic [ADDR_W-1:0] a);
    if (int'(a) < NUM_REGS) return mem_q[int'(p)*NUM_REGS + int'(a)];
    return '0;
  endfunction

  assign m_rdata_o = pick(m_port_i, m_addr_i);
  assign l_rdata_o = pick(l_port_i, l_addr_i);

  a_r9_unimpl_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_we_i && int'(l_addr_i) >= NUM_REGS && !m_we_i) |=> $stable(mem_q));
  a_r9_bus_unimpl_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_we_i && int'(m_addr_i) >= NUM_REGS && !l_we_i) |=> $stable(mem_q));
endmodule

// File: rtl/mdio_mport_slave.sv
module mdio_mport_slave
  import mdio_mps_pkg::*;
#(
  parameter int NUM_PORTS   = 8,
  parameter int NUM_REGS    = 4,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdc_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mgmt_dis_i,
  input  logic              strap_lite_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              loc_we_i,
  input  logic [PW-1:0]     loc_port_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [DATA_W-1:0] loc_wdata_i,
  output logic [DATA_W-1:0] loc_rdata_o
);
  logic              rise, sbit, wr_en, oe;
  logic [ADDR_W-1:0] base_eff, reg_a;
  logic [PW-1:0]     port_a;
  logic [DATA_W-1:0] rd_data, wr_data;

  assign base_eff = strap_lite_i ? {base_addr_i[ADDR_W-1:3], 3'b000} : base_addr_i;

  mdio_mps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .mdc_i, .mdio_i, .rise_o(rise), .bit_o(sbit)
  );

  mdio_mps_fsm #(.NUM_PORTS(NUM_PORTS), .PRE_LEN(PRE_LEN)) u_fsm (
    .clk_i, .rst_ni,
    .rise_i(rise), .bit_i(sbit), .dis_i(mgmt_dis_i), .base_i(base_eff),
    .rd_data_i(rd_data), .port_o(port_a), .reg_o(reg_a),
    .wr_en_o(wr_en), .wr_data_o(wr_data),
    .mdio_o(mdio_o), .mdio_oe_o(oe)
  );

  mdio_mps_regs #(.NUM_PORTS(NUM_PORTS), .NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .m_we_i(wr_en), .m_port_i(port_a), .m_addr_i(reg_a),
    .m_wdata_i(wr_data), .m_rdata_o(rd_data),
    .l_we_i(loc_we_i), .l_port_i(loc_port_i), .l_addr_i(loc_addr_i),
    .l_wdata_i(loc_wdata_i), .l_rdata_o(loc_rdata_o)
  );

  assign mdio_oe_o = oe & ~mgmt_dis_i;
endmodule

// File: tb/mdio_mport_slave_bench.sv
module mdio_mport_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        m_en = 1'b0;
  logic        m_val = 1'b1;
  logic        dis = 1'b0;
  logic        lite = 1'b0;
  logic [4:0]  base = 5'd5;
  logic        lwe = 1'b0;
  logic [2:0]  lport = '0;
  logic [4:0]  laddr = '0;
  logic [15:0] lwdata = '0;
  logic [15:0] lrdata;
  logic        mdio_o, mdio_oe;
  logic        line;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  assign line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

  mdio_mport_slave u_mdio_mport_slave (
    .clk_i(clk), .rst_ni(rst_n), .mdc_i(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .mgmt_dis_i(dis), .strap_lite_i(lite), .base_addr_i(base),
    .loc_we_i(lwe), .loc_port_i(lport), .loc_addr_i(laddr),
    .loc_wdata_i(lwdata), .loc_rdata_o(lrdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one MDC period: drive at low phase, sample the line just before the rise
  task automatic bit_xfer(input logic drv, input logic v, output logic s_oe, output logic s_o);
    mdc = 1'b0; m_en = drv; m_val = v;
    repeat (4) @(negedge clk);
    s_oe = mdio_oe; s_o = mdio_o;
    mdc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output logic ok, output logic drv);
    logic so, sv;
    logic is_rd;
    is_rd = (op == 2'b10);
    drv = 1'b0; ok = 1'b1; rd = '0;
    bit_xfer(1'b1, 1'b0, so, sv); drv |= so;
    for (int i = 0; i < pre; i++) begin bit_xfer(1'b1, 1'b1, so, sv); drv |= so; end
    for (int i = 1; i >= 0; i--) begin bit_xfer(1'b1, st[i], so, sv); drv |= so; end
    for (int i = 1; i >= 0; i--) begin bit_xfer(1'b1, op[i], so, sv); drv |= so; end
    for (int i = 4; i >= 0; i--) begin bit_xfer(1'b1, phy[i], so, sv); drv |= so; end
    for (int i = 4; i >= 0; i--) begin bit_xfer(1'b1, ra[i], so, sv); drv |= so; end
    if (is_rd) begin
      bit_xfer(1'b0, 1'b1, so, sv); drv |= so; if (so) ok = 1'b0;
      bit_xfer(1'b0, 1'b1, so, sv); drv |= so; if (!so || sv) ok = 1'b0;
      for (int i = 15; i >= 0; i--) begin
        bit_xfer(1'b0, 1'b1, so, sv); drv |= so;
        if (!so) ok = 1'b0;
        rd[i] = so ? sv : 1'b1;
      end
    end else begin
      bit_xfer(1'b1, 1'b1, so, sv); drv |= so;
      bit_xfer(1'b1, 1'b0, so, sv); drv |= so;
      for (int i = 15; i >= 0; i--) begin bit_xfer(1'b1, wd[i], so, sv); drv |= so; end
    end
    bit_xfer(1'b0, 1'b1, so, sv);
    if (so) ok = 1'b0;
    m_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                    output logic drv);
    logic [15:0] rd; logic ok;
    frame(32, 2'b01, 2'b01, phy, ra, wd, rd, ok, drv);
  endtask

  task automatic rdf(input logic [4:0] phy, input logic [4:0] ra, output logic [15:0] rd,
                     output logic ok, output logic drv);
    frame(32, 2'b01, 2'b10, phy, ra, 16'h0, rd, ok, drv);
  endtask

  task automatic lread(input logic [2:0] p, input logic [4:0] a, output logic [15:0] d);
    lport = p; laddr = a;
    @(negedge clk);
    d = lrdata;
  endtask

  task automatic lwrite(input logic [2:0] p, input logic [4:0] a, input logic [15:0] d);
    lport = p; laddr = a; lwdata = d; lwe = 1'b1;
    @(negedge clk);
    lwe = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R11 oe after reset", 32'(mdio_oe), 32'h0);
    lread(3'd0, 5'd0, d); chk("R11 port0 reg0", 32'(d), 32'h0);
    lread(3'd7, 5'd3, d); chk("R11 port7 reg3", 32'(d), 32'h0);
  endtask

  task automatic t_write_read;
    logic [15:0] d; logic ok, drv;
    wr(5'd5, 5'd1, 16'hA5C3, drv);
    chk("R5 no drive in write", 32'(drv), 32'h0);
    lread(3'd0, 5'd1, d); chk("R5 stored", 32'(d), 32'hA5C3);
    rdf(5'd5, 5'd1, d, ok, drv);
    chk("R4 read data", 32'(d), 32'hA5C3);
    chk("R4 turnaround and release", 32'(ok), 32'h1);
  endtask

  task automatic t_offset;
    logic [15:0] d; logic ok, drv;
    wr(5'd12, 5'd2, 16'h0F0F, drv);
    lread(3'd7, 5'd2, d); chk("R3 port7 by base+7", 32'(d), 32'h0F0F);
    lread(3'd0, 5'd2, d); chk("R3 port0 untouched", 32'(d), 32'h0);
    wr(5'd8, 5'd1, 16'h1357, drv);
    rdf(5'd8, 5'd1, d, ok, drv);
    chk("R3 port3 read back", 32'(d), 32'h1357);
  endtask

  task automatic t_wrap;
    logic [15:0] d; logic drv;
    base = 5'd30;
    wr(5'd1, 5'd3, 16'hBEEF, drv);
    lread(3'd3, 5'd3, d); chk("R3 modulo-32 wrap", 32'(d), 32'hBEEF);
    base = 5'd5;
  endtask

  task automatic t_miss;
    logic [15:0] d, acc; logic ok, drv;
    rdf(5'd20, 5'd1, d, ok, drv);
    chk("R6 no drive on miss", 32'(drv), 32'h0);
    wr(5'd20, 5'd0, 16'hFFFF, drv);
    acc = '0;
    for (int p = 0; p < 8; p++) begin lread(3'(p), 5'd0, d); acc |= d; end
    chk("R6 no write on miss", 32'(acc), 32'h0);
    rdf(5'd5, 5'd1, d, ok, drv);
    chk("R6 re-armed read", 32'(d), 32'hA5C3);
  endtask

  task automatic t_preamble;
    logic [15:0] d; logic ok, drv;
    frame(31, 2'b01, 2'b01, 5'd5, 5'd0, 16'h1111, d, ok, drv);
    lread(3'd0, 5'd0, d); chk("R1 short write ignored", 32'(d), 32'h0);
    frame(31, 2'b01, 2'b10, 5'd5, 5'd1, 16'h0, d, ok, drv);
    chk("R1 short read silent", 32'(drv), 32'h0);
    frame(40, 2'b01, 2'b01, 5'd5, 5'd0, 16'h4444, d, ok, drv);
    lread(3'd0, 5'd0, d); chk("R1 long preamble ok", 32'(d), 32'h4444);
  endtask

  task automatic t_bad_code;
    logic [15:0] d; logic ok, drv;
    frame(32, 2'b01, 2'b11, 5'd5, 5'd1, 16'h0000, d, ok, drv);
    chk("R2 bad opcode silent", 32'(drv), 32'h0);
    lread(3'd0, 5'd1, d); chk("R2 bad opcode no write", 32'(d), 32'hA5C3);
    frame(32, 2'b00, 2'b01, 5'd5, 5'd1, 16'h0000, d, ok, drv);
    lread(3'd0, 5'd1, d); chk("R2 bad start no write", 32'(d), 32'hA5C3);
  endtask

  task automatic t_disable;
    logic [15:0] d; logic ok, drv;
    dis = 1'b1;
    wr(5'd5, 5'd1, 16'h0000, drv);
    lread(3'd0, 5'd1, d); chk("R7 write blocked", 32'(d), 32'hA5C3);
    rdf(5'd5, 5'd1, d, ok, drv);
    chk("R7 never drives", 32'(drv), 32'h0);
    dis = 1'b0;
    rdf(5'd5, 5'd1, d, ok, drv);
    chk("R7 read after enable", 32'(d), 32'hA5C3);
  endtask

  task automatic t_strap;
    logic [15:0] d; logic drv;
    lite = 1'b1; base = 5'd13;
    wr(5'd10, 5'd2, 16'h2222, drv);
    lread(3'd2, 5'd2, d); chk("R8 base forced to 8", 32'(d), 32'h2222);
    wr(5'd15, 5'd2, 16'h3333, drv);
    lread(3'd7, 5'd2, d); chk("R8 port7 at 15", 32'(d), 32'h3333);
    lite = 1'b0; base = 5'd5;
  endtask

  task automatic t_unimpl;
    logic [15:0] d; logic ok, drv;
    wr(5'd5, 5'd9, 16'h9999, drv);
    rdf(5'd5, 5'd9, d, ok, drv);
    chk("R9 read unimplemented zero", 32'(d), 32'h0);
    chk("R9 read timing", 32'(ok), 32'h1);
    lread(3'd0, 5'd9, d); chk("R9 local unimplemented", 32'(d), 32'h0);
    lread(3'd0, 5'd1, d); chk("R9 no alias", 32'(d), 32'hA5C3);
  endtask

  task automatic t_local;
    logic [15:0] d; logic ok, drv;
    lwrite(3'd4, 5'd3, 16'h7A7A);
    lread(3'd4, 5'd3, d); chk("R10 local write", 32'(d), 32'h7A7A);
    rdf(5'd9, 5'd3, d, ok, drv);
    chk("R10 bus sees local", 32'(d), 32'h7A7A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_write_read;
    t_offset;
    t_wrap;
    t_miss;
    t_preamble;
    t_bad_code;
    t_disable;
    t_strap;
    t_unimpl;
    t_local;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule